// File: doc/BRIEF.md
# Transfer Count and Completion Controller

This block holds the counting and completion logic for one channel of a data transfer controller. A host loads a 16-bit count word and a small configuration: a transfer mode, a chain-enable bit and an interrupt-select bit. After that, the engine that moves the data pulses a strobe once per finished transfer. On each strobe the block updates the count in the way the current mode requires. It then decides whether the programmed sequence has ended.

There are three modes. In normal mode the whole word is one down-counter. In repeat mode and block mode the word splits into a reload byte in the upper half and an 8-bit down-counter in the lower half. The block raises four kinds of one-cycle pulse: end of count, a CPU interrupt request, a request to clear the interrupt source flag that started the transfer, and a request to clear the channel's activation enable. Chain-enable suppresses completion handling so that a following channel can continue the sequence.

The block also checks the 24-bit source and destination addresses. For word-size transfers it flags an odd address. Address generation, arbitration and chain sequencing are handled elsewhere.

Top module: `xfer_count_ctl`

## Requirements
- R1: After a synchronous active-high reset, the count reads 0 and all five outputs are low. The configuration resets to normal mode with chain-enable 0 and interrupt-select 0.
- R2: A host count write is visible on `cnt_rdata` one cycle later. A strobe in the same cycle as the write is dropped completely: the count does not change and no output pulse is raised.
- R3: In normal mode (`cfg_mode` 00), each strobe decrements the 16-bit count by one, wrapping from 0 to FFFF. When the count steps from 1 to 0, the sequence has ended. A loaded 0 therefore gives 65536 transfers.
- R4: In repeat mode (01) and block mode (10), a strobe decrements only the lower byte and leaves the upper byte unchanged. When the lower byte would reach zero, it is loaded with the upper byte instead. A lower byte of 0 gives 256 transfers.
- R5: In repeat mode, reaching zero on the lower byte never ends the sequence. In block mode, it does end the sequence.
- R6: When a sequence ends with chain-enable 0, `end_of_count`, `clr_src_flag`, `clr_enable` and `cpu_irq` are each high for exactly the one cycle after the strobe.
- R7: With chain-enable 1, a strobe never raises `end_of_count`, `clr_src_flag` or `clr_enable`, even when the count ends. The count is still updated.
- R8: With interrupt-select 1, every accepted strobe raises `cpu_irq` in the next cycle. With interrupt-select 0, `cpu_irq` is raised only when a sequence ends with chain-enable 0.
- R9: Mode code 11 behaves exactly like normal mode. A configuration write takes effect from the next cycle; a strobe in the same cycle uses the old configuration.
- R10: One cycle after the inputs are presented, `align_err` shows whether `word_size` is 1 and bit 0 of either address is 1. For byte transfers it is always 0.
- R11: In a cycle after one with no accepted strobe, all four completion outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the configuration fields |
| cfg_mode | input | 2 | 00 normal, 01 repeat, 10 block, 11 as normal |
| cfg_chain | input | 1 | Chain-enable |
| cfg_isel | input | 1 | Interrupt-select: raise an interrupt on every transfer |
| cnt_we | input | 1 | Load the count word |
| cnt_wdata | input | 16 | Count word to load |
| cnt_rdata | output | 16 | Current count word |
| xfer_done | input | 1 | One-cycle strobe per finished transfer |
| word_size | input | 1 | 1 for word transfers, 0 for byte transfers |
| src_addr | input | 24 | Source address |
| dst_addr | input | 24 | Destination address |
| end_of_count | output | 1 | Sequence-ended pulse |
| cpu_irq | output | 1 | CPU interrupt request pulse |
| clr_src_flag | output | 1 | Request to clear the interrupt source flag |
| clr_enable | output | 1 | Request to clear the activation enable bit |
| align_err | output | 1 | Odd address on a word transfer |

## Verification
A wrong count value appears on `cnt_rdata` one cycle after the strobe that produced it. A bad reload shows up the first time the lower byte wraps, because the upper byte is not copied in. A wrong completion decision shows up as a missing or extra pulse on the four completion outputs in the cycle right after the terminal strobe. Chain or interrupt-select mishandling shows up as a wrong pulse pattern in that same cycle. Random strobes, loads and configuration changes with small count values reach the terminal and reload cases often. Every output is compared after every cycle, so a fault shows up within one cycle of the transfer that exposes it.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_ALT    = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/xfc_counter.sv
module xfc_counter
  import xfc_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2*SEG_W-1:0] wdata,
  input  logic               xfer,
  input  xfer_mode_e         mode,
  output logic [2*SEG_W-1:0] cnt_q,
  output logic               term
);
  localparam int CNT_W = 2 * SEG_W;

  logic [SEG_W-1:0] lo, hi;
  logic             split;

  assign lo    = cnt_q[SEG_W-1:0];
  assign hi    = cnt_q[CNT_W-1:SEG_W];
  assign split = (mode == XM_REPEAT) || (mode == XM_BLOCK);

  // Terminal decision for the current count (before this strobe applies)
  always_comb begin
    case (mode)
      XM_REPEAT: term = 1'b0;
      XM_BLOCK:  term = (lo == SEG_W'(1));
      default:   term = (cnt_q == CNT_W'(1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (we) begin
      cnt_q <= wdata;
    end else if (xfer) begin
      if (split) begin
        if (lo == SEG_W'(1)) cnt_q[SEG_W-1:0] <= hi;
        else                 cnt_q[SEG_W-1:0] <= lo - 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (cnt_q == $past(wdata)));

  assert_full_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer && !we && !split) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer && !we && split && (lo == SEG_W'(1))) |=>
      (cnt_q[SEG_W-1:0] == $past(cnt_q[CNT_W-1:SEG_W])));

  assert_hi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer && !we && split) |=> (cnt_q[CNT_W-1:SEG_W] == $past(cnt_q[CNT_W-1:SEG_W])));
endmodule

// File: rtl/xfc_events.sv
module xfc_events (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  input  logic term,
  input  logic chain,
  input  logic isel,
  output logic eoc_q,
  output logic irq_q,
  output logic clr_src_q,
  output logic clr_en_q
);
  logic fin;

  assign fin = xfer & term & ~chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_q     <= 1'b0;
      irq_q     <= 1'b0;
      clr_src_q <= 1'b0;
      clr_en_q  <= 1'b0;
    end else begin
      eoc_q     <= fin;
      clr_src_q <= fin;
      clr_en_q  <= fin;
      irq_q     <= xfer & (isel | fin);
    end
  end

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> !(eoc_q || irq_q || clr_src_q || clr_en_q));

  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer && chain) |=> !(eoc_q || clr_src_q || clr_en_q));

  assert_isel_every_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer && isel) |=> irq_q);

  assert_end_irq_R6: assert property (@(posedge clk) disable iff (rst)
    eoc_q |-> (irq_q && clr_src_q && clr_en_q));
endmodule

// File: rtl/xfc_align.sv
module xfc_align #(
  parameter int ADDR_W     = 24,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_size,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              err_q
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(WORD_BYTES - 1);

  logic misal;
  assign misal = ((src & MASK) != '0) || ((dst & MASK) != '0);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= word_size & misal;
  end

  assert_byte_ok_R10: assert property (@(posedge clk) disable iff (rst)
    !word_size |=> !err_q);

  assert_odd_src_R10: assert property (@(posedge clk) disable iff (rst)
    (word_size && src[0]) |=> err_q);
endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl
  import xfc_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_chain,
  input  logic               cfg_isel,
  input  logic               cnt_we,
  input  logic [2*SEG_W-1:0] cnt_wdata,
  output logic [2*SEG_W-1:0] cnt_rdata,
  input  logic               xfer_done,
  input  logic               word_size,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  output logic               end_of_count,
  output logic               cpu_irq,
  output logic               clr_src_flag,
  output logic               clr_enable,
  output logic               align_err
);
  xfer_mode_e mode_q;
  logic       chain_q, isel_q;
  logic       xfer_acc, term;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= XM_NORMAL;
      chain_q <= 1'b0;
      isel_q  <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= xfer_mode_e'(cfg_mode);
      chain_q <= cfg_chain;
      isel_q  <= cfg_isel;
    end
  end

  // A host write owns the cycle; the strobe is dropped
  assign xfer_acc = xfer_done & ~cnt_we;

  xfc_counter #(.SEG_W(SEG_W)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .we   (cnt_we),
    .wdata(cnt_wdata),
    .xfer (xfer_acc),
    .mode (mode_q),
    .cnt_q(cnt_rdata),
    .term (term)
  );

  xfc_events u_events (
    .clk      (clk),
    .rst      (rst),
    .xfer     (xfer_acc),
    .term     (term),
    .chain    (chain_q),
    .isel     (isel_q),
    .eoc_q    (end_of_count),
    .irq_q    (cpu_irq),
    .clr_src_q(clr_src_flag),
    .clr_en_q (clr_enable)
  );

  xfc_align #(.ADDR_W(ADDR_W), .WORD_BYTES(2)) u_align (
    .clk      (clk),
    .rst      (rst),
    .word_size(word_size),
    .src      (src_addr),
    .dst      (dst_addr),
    .err_q    (align_err)
  );

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_we && xfer_done) |=> !(cpu_irq || end_of_count));

  assert_repeat_no_end_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == XM_REPEAT) |=> !end_of_count);
endmodule

// File: tb/test_xfer_count_ctl.sv
`timescale 1ns/1ps
module test_xfer_count_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_chain = 0, cfg_isel = 0;
  logic [1:0]  cfg_mode = 0;
  logic        cnt_we = 0, xfer_done = 0, word_size = 0;
  logic [15:0] cnt_wdata = 0;
  logic [23:0] src_addr = 0, dst_addr = 0;
  logic [15:0] cnt_rdata;
  logic        end_of_count, cpu_irq, clr_src_flag, clr_enable, align_err;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [15:0] m_cnt = 0;
  logic [1:0]  m_mode = 0;
  logic        m_chain = 0, m_isel = 0;

  always #2.5 clk = ~clk;

  xfer_count_ctl i_xfer_count_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chain(cfg_chain), .cfg_isel(cfg_isel), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .xfer_done(xfer_done),
    .word_size(word_size), .src_addr(src_addr), .dst_addr(dst_addr),
    .end_of_count(end_of_count), .cpu_irq(cpu_irq), .clr_src_flag(clr_src_flag),
    .clr_enable(clr_enable), .align_err(align_err));

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic model_term(input logic [1:0] md, input logic [15:0] c);
    case (md)
      2'b01:   return 1'b0;
      2'b10:   return c[7:0] == 8'd1;
      default: return c == 16'd1;
    endcase
  endfunction

  function automatic logic [15:0] model_next(input logic [1:0] md, input logic [15:0] c);
    if (md == 2'b01 || md == 2'b10)
      return (c[7:0] == 8'd1) ? {c[15:8], c[15:8]} : {c[15:8], c[7:0] - 8'd1};
    return c - 16'd1;
  endfunction

  task automatic step(input string req, input logic we, input logic [15:0] wd,
                      input logic x, input logic cw, input logic [1:0] md,
                      input logic ch, input logic is, input logic ws,
                      input logic [23:0] sa, input logic [23:0] da);
    logic xe, fin, e_irq, e_al;
    cnt_we = we; cnt_wdata = wd; xfer_done = x; cfg_we = cw; cfg_mode = md;
    cfg_chain = ch; cfg_isel = is; word_size = ws; src_addr = sa; dst_addr = da;
    xe    = x & ~we;
    fin   = xe & model_term(m_mode, m_cnt) & ~m_chain;
    e_irq = xe & (m_isel | fin);
    e_al  = ws & (sa[0] | da[0]);
    if (we)      m_cnt = wd;
    else if (xe) m_cnt = model_next(m_mode, m_cnt);
    if (cw) begin m_mode = md; m_chain = ch; m_isel = is; end
    @(posedge clk);
    @(negedge clk);
    chk(req, "count", cnt_rdata, m_cnt);
    chk(req, "end_of_count", {15'd0, end_of_count}, {15'd0, fin});
    chk(req, "clr_src_flag", {15'd0, clr_src_flag}, {15'd0, fin});
    chk(req, "clr_enable", {15'd0, clr_enable}, {15'd0, fin});
    chk(req, "cpu_irq", {15'd0, cpu_irq}, {15'd0, e_irq});
    chk(req, "align_err", {15'd0, align_err}, {15'd0, e_al});
    cnt_we = 0; xfer_done = 0; cfg_we = 0;
  endtask

  task automatic cfg(input string req, input logic [1:0] md, input logic ch, input logic is);
    step(req, 0, 16'd0, 0, 1, md, ch, is, 0, 24'd0, 24'd0);
  endtask
  task automatic load(input string req, input logic [15:0] v);
    step(req, 1, v, 0, 0, 2'b00, 0, 0, 0, 24'd0, 24'd0);
  endtask
  task automatic pulse(input string req);
    step(req, 0, 16'd0, 1, 0, 2'b00, 0, 0, 0, 24'd0, 24'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "count", cnt_rdata, 16'd0);
    chk("R1", "outputs", {11'd0, end_of_count, cpu_irq, clr_src_flag, clr_enable, align_err}, 16'd0);
    step("R11", 0, 16'd0, 0, 0, 2'b00, 0, 0, 0, 24'd0, 24'd0);
    // normal mode: three transfers, end on third
    load("R2", 16'd3);
    pulse("R3"); pulse("R8"); pulse("R6");
    pulse("R3");                      // wrap 0 -> FFFF, no end
    load("R3", 16'd0); pulse("R3");
    // write beats strobe
    load("R2", 16'd5);
    step("R2", 1, 16'h0042, 1, 0, 2'b00, 0, 0, 0, 24'd0, 24'd0);
    // repeat mode with interrupt-select
    cfg("R9", 2'b01, 0, 1);
    load("R4", 16'h0302); pulse("R4"); pulse("R5"); pulse("R8");
    load("R4", 16'h0500); pulse("R4");
    // block mode: end when lower byte hits zero
    cfg("R9", 2'b10, 0, 0);
    load("R5", 16'h0201); pulse("R5"); pulse("R5");
    // chain suppresses completion
    cfg("R7", 2'b00, 1, 0);
    load("R7", 16'd1); pulse("R7");
    cfg("R7", 2'b10, 1, 1);
    load("R7", 16'h0101); pulse("R7");
    // mode 11 as normal; config change same cycle as strobe uses old config
    cfg("R9", 2'b11, 0, 0);
    load("R9", 16'd1); pulse("R9");
    load("R9", 16'd2);
    step("R9", 0, 16'd0, 1, 1, 2'b01, 0, 0, 0, 24'd0, 24'd0);
    pulse("R9");
    // alignment
    step("R10", 0, 16'd0, 0, 0, 2'b00, 0, 0, 1, 24'h000101, 24'h000200);
    step("R10", 0, 16'd0, 0, 0, 2'b00, 0, 0, 0, 24'hFFFFFF, 24'h000001);
    step("R10", 0, 16'd0, 0, 0, 2'b00, 0, 0, 1, 24'hFFFFFE, 24'h000002);
    step("R10", 0, 16'd0, 0, 0, 2'b00, 0, 0, 1, 24'h000000, 24'h800003);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic we, x, cw, ws;
      logic [15:0] wd;
      we = ($urandom_range(0, 15) == 0);
      cw = ($urandom_range(0, 31) == 0);
      x  = $urandom_range(0, 1) == 1;
      ws = $urandom_range(0, 1) == 1;
      wd = {4'd0, 4'($urandom_range(0, 3)), 4'd0, 4'($urandom_range(0, 4))};
      if ($urandom_range(0, 7) == 0) wd = 16'($urandom);
      step("R3/R4/R6", we, wd, x, cw, 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), ws,
           24'($urandom), 24'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule